// File: doc/BRIEF.md
# Character LCD Host Bus Interface

This block sits between a host microprocessor and the core of a character LCD controller. The host drives an asynchronous parallel bus with three strobes: a register-select line, a read/write line and an enable line whose pulses frame each transfer. The block brings the enable line into the system clock domain and spots its edges. Writes go to the instruction register or to the data register, and the block hands the core a one-cycle strobe carrying the full byte. Reads return either a status byte or a RAM byte from the core, and the data bus is driven only while the read is in progress.

The bus can be eight bits wide, or four bits wide using only the upper four lines. In four-bit mode every byte moves as two enable pulses, high nibble first. A one-bit phase tracks which half is due, and it returns to the high half whenever the width setting changes. Instruction execution, the RAM arrays and the display scan sit outside this block. The core appears only as a busy input, an address counter input and a read-data input.

Top module: `lcdbus_host_if`

## Requirements
- R1: A write with `bus_rs`=0 and `bus_rw`=0 gives a one-cycle `instr_wr` pulse with the written byte on `wr_byte`, a few clocks after `bus_e` falls.
- R2: A write with `bus_rs`=1 gives a one-cycle `data_wr` pulse with the written byte on `wr_byte`, and no `instr_wr`.
- R3: A read with `bus_rs`=0 and `bus_rw`=1 presents a status byte. Bit 7 is `core_busy` and bits 6..0 are `core_addr`, both captured when the enable rise is detected. It gives no `data_rd` pulse.
- R4: A read with `bus_rs`=1 presents `core_rd_data`. Once the transfer completes (in four-bit mode, after its second pulse), exactly one one-cycle `data_rd` pulse follows.
- R5: `bus_d_oe` is 1 only while a read transfer's enable is high. It is 0 during writes and when idle, and `bus_d_out` is all zeros whenever `bus_d_oe` is 0.
- R6: In four-bit mode (`mode_8bit`=0), a write takes its high nibble from `bus_d_in[7:4]` on the first pulse and its low nibble from `bus_d_in[7:4]` on the second. `bus_d_in[3:0]` is ignored, and no write strobe appears after the first pulse.
- R7: In four-bit mode a read puts bits 7..4 of the byte on `bus_d_out[7:4]` during the first pulse and bits 3..0 during the second. `bus_d_out[3:0]` stays 0 throughout.
- R8: Any change of `mode_8bit` returns the nibble phase to the high half, so a half-finished pair is dropped and the next transfer starts a fresh byte.
- R9: `instr_wr`, `data_wr` and `data_rd` each last one cycle, and at most one of them is high in any cycle.
- R10: Transfers are all accepted back to back when `bus_e` stays high, and then low, for at least SYNC_STAGES+2 clock cycles each.
- R11: After reset `bus_d_oe`, `bus_d_out`, all strobes and `wr_byte` are 0 and the phase is the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_8bit | input | 1 | 1: eight-bit bus, 0: four-bit bus on the upper lines |
| bus_e | input | 1 | Asynchronous enable strobe from the host |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 0 write, 1 read |
| bus_d_in | input | 8 | Data lines as seen from the host |
| bus_d_out | output | 8 | Read data driven toward the host |
| bus_d_oe | output | 1 | Tri-state output enable for the data lines |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Address counter from the core |
| core_rd_data | input | 8 | RAM byte at the current address |
| instr_wr | output | 1 | One-cycle instruction register write strobe |
| data_wr | output | 1 | One-cycle data register write strobe |
| data_rd | output | 1 | One-cycle strobe after a completed data read |
| wr_byte | output | 8 | Byte carried with a write strobe |

## Verification
The assertions assume that the host keeps `bus_rs`, `bus_rw` and the data lines steady for the whole time enable is high. They also assume that enable high and low phases last long enough for the synchroniser to see every edge, and that `mode_8bit` changes only between whole bytes or as a deliberate reset of the phase. The stimulus sets the strobes and data one cycle before raising enable and holds them until the next transfer begins. Enable high and low widths are drawn at random but never below the R10 minimum. Width changes happen only between operations, except in the directed half-pair cases that exercise R8.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;

   // access kind, encoded as {rs, rw}
   typedef enum logic [1:0] {
      ACC_INSTR_WR  = 2'b00,
      ACC_STATUS_RD = 2'b01,
      ACC_DATA_WR   = 2'b10,
      ACC_DATA_RD   = 2'b11
   } acc_e;

   function automatic acc_e decode_acc(input logic rs, input logic rw);
      return acc_e'({rs, rw});
   endfunction
endpackage

// File: rtl/lcdbus_sync.sv
module lcdbus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lcdbus_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[0] <= 1'b0;
               else        ff[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[i] <= 1'b0;
               else        ff[i] <= ff[i-1];
         end
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/lcdbus_nibble.sv
module lcdbus_nibble
   import lcdbus_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_8bit,
   input  logic              fall,
   input  acc_e              acc,
   input  logic [BYTE_W-1:0] din,
   output logic              instr_wr,
   output logic              data_wr,
   output logic              data_rd,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              low_phase
);
   logic             mode_q;
   logic [NIB_W-1:0] hi_nib;
   logic             done;
   logic [BYTE_W-1:0] full;

   assign done = mode_8bit | low_phase;
   assign full = mode_8bit ? din : {hi_nib, din[BYTE_W-1 -: NIB_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         low_phase <= 1'b0;
         hi_nib    <= '0;
         instr_wr  <= 1'b0;
         data_wr   <= 1'b0;
         data_rd   <= 1'b0;
         wr_byte   <= '0;
      end else begin
         instr_wr <= 1'b0;
         data_wr  <= 1'b0;
         data_rd  <= 1'b0;
         mode_q   <= mode_8bit;
         if (mode_q != mode_8bit) begin
            low_phase <= 1'b0;
         end else if (fall) begin
            if (!mode_8bit) low_phase <= ~low_phase;
            if (!mode_8bit && !low_phase)
               hi_nib <= din[BYTE_W-1 -: NIB_W];
            if (done) begin
               unique case (acc)
                  ACC_INSTR_WR: begin instr_wr <= 1'b1; wr_byte <= full; end
                  ACC_DATA_WR:  begin data_wr  <= 1'b1; wr_byte <= full; end
                  ACC_DATA_RD:  data_rd <= 1'b1;
                  default:      ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/lcdbus_rdpath.sv
module lcdbus_rdpath
   import lcdbus_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              mode_8bit,
   input  logic              low_phase,
   input  logic              rs,
   input  logic              rw,
   input  logic              core_busy,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [BYTE_W-1:0] core_rd_data,
   output logic [BYTE_W-1:0] d_out,
   output logic              oe
);
   logic [BYTE_W-1:0] snap;
   logic              rd_active;

   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad_addr
         $error("lcdbus_rdpath: ADDR_W must leave exactly one bit for busy");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap      <= '0;
         rd_active <= 1'b0;
      end else if (rise) begin
         rd_active <= rw;
         if (rw && (mode_8bit || !low_phase))
            snap <= rs ? core_rd_data : {core_busy, core_addr};
      end else if (fall) begin
         rd_active <= 1'b0;
      end
   end

   always_comb begin
      d_out = '0;
      if (rd_active) begin
         if (mode_8bit)      d_out = snap;
         else if (low_phase) d_out = {snap[NIB_W-1:0], {NIB_W{1'b0}}};
         else                d_out = {snap[BYTE_W-1 -: NIB_W], {NIB_W{1'b0}}};
      end
   end

   assign oe = rd_active;
endmodule

// File: rtl/lcdbus_host_if.sv
module lcdbus_host_if
   import lcdbus_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_8bit,
   input  logic              bus_e,
   input  logic              bus_rs,
   input  logic              bus_rw,
   input  logic [7:0]        bus_d_in,
   output logic [7:0]        bus_d_out,
   output logic              bus_d_oe,
   input  logic              core_busy,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [7:0]        core_rd_data,
   output logic              instr_wr,
   output logic              data_wr,
   output logic              data_rd,
   output logic [7:0]        wr_byte
);
   logic e_sync, e_prev, e_rise, e_fall;
   logic hold_rs, hold_rw;
   logic [BYTE_W-1:0] hold_d;
   logic low_phase;

   lcdbus_sync #(.STAGES(SYNC_STAGES)) e_sync_i (
      .clk(clk), .rst_n(rst_n), .d(bus_e), .q(e_sync));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_prev  <= 1'b0;
         hold_rs <= 1'b0;
         hold_rw <= 1'b0;
         hold_d  <= '0;
      end else begin
         e_prev <= e_sync;
         if (e_sync) begin
            hold_rs <= bus_rs;
            hold_rw <= bus_rw;
            hold_d  <= bus_d_in;
         end
      end
   end

   assign e_rise = e_sync & ~e_prev;
   assign e_fall = ~e_sync & e_prev;

   lcdbus_nibble nib_i (
      .clk(clk), .rst_n(rst_n), .mode_8bit(mode_8bit), .fall(e_fall),
      .acc(decode_acc(hold_rs, hold_rw)), .din(hold_d),
      .instr_wr(instr_wr), .data_wr(data_wr), .data_rd(data_rd),
      .wr_byte(wr_byte), .low_phase(low_phase));

   lcdbus_rdpath #(.ADDR_W(ADDR_W)) rd_i (
      .clk(clk), .rst_n(rst_n), .rise(e_rise), .fall(e_fall),
      .mode_8bit(mode_8bit), .low_phase(low_phase),
      .rs(bus_rs), .rw(bus_rw), .core_busy(core_busy),
      .core_addr(core_addr), .core_rd_data(core_rd_data),
      .d_out(bus_d_out), .oe(bus_d_oe));
endmodule

// File: rtl/lcdbus_host_if_chk.sv
module lcdbus_host_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_8bit,
   input logic       bus_rw,
   input logic [7:0] bus_d_out,
   input logic       bus_d_oe,
   input logic       instr_wr,
   input logic       data_wr,
   input logic       data_rd
);
   // R1
   instr_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_wr |=> !instr_wr);
   // R2
   data_wr_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !data_wr);
   // R4
   data_rd_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |=> !data_rd);
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({instr_wr, data_wr, data_rd}) <= 1);
   // R5
   oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_d_oe |-> bus_rw);
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_d_oe |-> (bus_d_out == 8'h00));
   // R7
   nib_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_d_oe && !mode_8bit) |-> (bus_d_out[3:0] == 4'h0));
   // R3
   read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_d_oe && $past(bus_d_oe) && $stable(mode_8bit)) |-> $stable(bus_d_out));
endmodule

bind lcdbus_host_if lcdbus_host_if_chk chk_i (
   .clk(clk), .rst_n(rst_n), .mode_8bit(mode_8bit), .bus_rw(bus_rw),
   .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .instr_wr(instr_wr),
   .data_wr(data_wr), .data_rd(data_rd));

// File: tb/lcdbus_host_if_tb_top.sv
module lcdbus_host_if_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_8bit = 1'b1;
   logic bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
   logic [7:0] bus_d_in = '0;
   logic [7:0] bus_d_out;
   logic bus_d_oe;
   logic core_busy = 1'b0;
   logic [6:0] core_addr = '0;
   logic [7:0] core_rd_data = '0;
   logic instr_wr, data_wr, data_rd;
   logic [7:0] wr_byte;

   int n_chk = 0, n_bad = 0;
   int n_instr = 0, n_dwr = 0, n_drd = 0;
   logic [7:0] last_wr = '0;
   logic [7:0] seen_d;
   logic seen_oe;
   bit done = 0;

   always #5 clk = ~clk;

   lcdbus_host_if dut_i (
      .clk(clk), .rst_n(rst_n), .mode_8bit(mode_8bit), .bus_e(bus_e),
      .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_d_in(bus_d_in),
      .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .core_busy(core_busy),
      .core_addr(core_addr), .core_rd_data(core_rd_data),
      .instr_wr(instr_wr), .data_wr(data_wr), .data_rd(data_rd),
      .wr_byte(wr_byte));

   always @(negedge clk) if (rst_n) begin
      if (instr_wr) begin n_instr++; last_wr = wr_byte; end
      if (data_wr)  begin n_dwr++;   last_wr = wr_byte; end
      if (data_rd)  n_drd++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] status_byte(input logic b, input logic [6:0] a);
      return {b, a};
   endfunction

   function automatic logic [7:0] nib_view(input logic [7:0] v, input bit second);
      return second ? {v[3:0], 4'h0} : {v[7:4], 4'h0};
   endfunction

   // one enable pulse; R10: high and low phases of at least 4 cycles
   task automatic xfer(input logic rs, input logic rw, input logic [7:0] d);
      int hi = 4 + int'($urandom % 4);
      int lo = 4 + int'($urandom % 4);
      @(negedge clk);
      bus_rs = rs; bus_rw = rw; bus_d_in = d;
      @(negedge clk);
      bus_e = 1'b1;
      repeat (hi) @(negedge clk);
      seen_d = bus_d_out; seen_oe = bus_d_oe;
      bus_e = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic write_op(input logic rs, input logic [7:0] v);
      int i0 = n_instr, w0 = n_dwr;
      if (mode_8bit) begin
         xfer(rs, 1'b0, v);
         check(!seen_oe, "R5 write oe", seen_oe, 0);
      end else begin
         xfer(rs, 1'b0, {v[7:4], 4'($urandom)});
         check(!seen_oe, "R5 write oe", seen_oe, 0);
         check(n_instr == i0 && n_dwr == w0, "R6 no strobe after first nibble",
               n_instr + n_dwr, i0 + w0);
         xfer(rs, 1'b0, {v[3:0], 4'($urandom)});
      end
      if (rs) begin
         check(n_dwr == w0 + 1 && n_instr == i0, "R2 data_wr count", n_dwr, w0 + 1);
         check(last_wr == v, mode_8bit ? "R2 data byte" : "R6 data byte", last_wr, v);
      end else begin
         check(n_instr == i0 + 1 && n_dwr == w0, "R1 instr_wr count", n_instr, i0 + 1);
         check(last_wr == v, mode_8bit ? "R1 instr byte" : "R6 instr byte", last_wr, v);
      end
   endtask

   task automatic read_op(input logic rs);
      int r0 = n_drd;
      logic [7:0] exp;
      @(negedge clk);
      core_busy = 1'($urandom); core_addr = 7'($urandom); core_rd_data = 8'($urandom);
      exp = rs ? core_rd_data : status_byte(core_busy, core_addr);
      if (mode_8bit) begin
         xfer(rs, 1'b1, 8'($urandom));
         check(seen_oe, "R5 read oe", seen_oe, 1);
         check(seen_d == exp, rs ? "R4 read data" : "R3 status", seen_d, exp);
      end else begin
         xfer(rs, 1'b1, 8'($urandom));
         check(seen_oe && seen_d == nib_view(exp, 0), "R7 first nibble", seen_d, nib_view(exp, 0));
         check(n_drd == r0, "R4 no data_rd mid pair", n_drd, r0);
         xfer(rs, 1'b1, 8'($urandom));
         check(seen_oe && seen_d == nib_view(exp, 1), "R7 second nibble", seen_d, nib_view(exp, 1));
      end
      check(n_drd == r0 + (rs ? 1 : 0), rs ? "R4 data_rd count" : "R3 no data_rd",
            n_drd, r0 + (rs ? 1 : 0));
      check(!bus_d_oe && bus_d_out == 8'h00, "R5 released after read", bus_d_out, 0);
   endtask

   initial begin
      void'($urandom(32'h1CD5));
      repeat (3) @(negedge clk);
      // R11 reset state
      check(!bus_d_oe && bus_d_out == 0, "R11 bus idle in reset", bus_d_out, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!instr_wr && !data_wr && !data_rd && wr_byte == 0, "R11 strobes idle",
            {instr_wr, data_wr, data_rd}, 0);

      // directed corners in 8-bit mode
      write_op(1'b0, 8'h00);
      write_op(1'b1, 8'hFF);
      core_busy = 1'b1;
      read_op(1'b0);
      read_op(1'b1);

      // 4-bit directed
      mode_8bit = 1'b0;
      repeat (3) @(negedge clk);
      write_op(1'b0, 8'hA5);
      write_op(1'b1, 8'h3C);
      read_op(1'b0);
      read_op(1'b1);

      // R8: half pair then width change to 8-bit
      xfer(1'b0, 1'b0, 8'hE0);
      mode_8bit = 1'b1;
      repeat (3) @(negedge clk);
      write_op(1'b0, 8'h5C);
      check(last_wr == 8'h5C, "R8 8-bit byte after width change", last_wr, 8'h5C);
      // R8: half pair, toggle width twice, fresh 4-bit pair
      mode_8bit = 1'b0;
      repeat (3) @(negedge clk);
      xfer(1'b1, 1'b0, 8'h90);
      mode_8bit = 1'b1;
      repeat (3) @(negedge clk);
      mode_8bit = 1'b0;
      repeat (3) @(negedge clk);
      write_op(1'b1, 8'hA7);
      check(last_wr == 8'hA7, "R8 fresh pair after width toggles", last_wr, 8'hA7);

      // constrained random mix
      for (int i = 0; i < 120; i++) begin
         if ($urandom % 8 == 0) begin
            mode_8bit = ~mode_8bit;
            repeat (3) @(negedge clk);
         end
         if ($urandom % 2) write_op(1'($urandom), 8'($urandom));
         else              read_op(1'($urandom));
      end
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule